// File: doc/BRIEF.md
# Triple-Channel Up-Counting Watchdog Timer

This peripheral holds three independent watchdog channels behind a flat 32-bit register port. Each channel owns an up-counter that advances by one on every clock where the shared tick enable is high, a compare value called the bite time, and a small control word. Software keeps a channel quiet by overwriting its counter, normally with zero, before the counter reaches the bite time. Once reset enable is set and the counter is at or above the bite time, the channel raises a registered reset request.

Channel 0 requests a recovery-mode reset. It also carries a second compare value, the bark time, which sets a sticky status flag and drives a maskable interrupt. Software clears that flag by writing one to it. Channels 1 and 2 both feed a single normal system reset request. Setting the bite time and the counter both to zero with reset enable on gives an immediate reset request, which serves as a software-triggered restart.

Top module: `wdog3_top`

## Requirements
- R1: After the active-low reset, every counter, bite, bark and control register reads zero, and rst_recovery_req, rst_system_req and irq are all low.
- R2: A counter increases by exactly one on each clock edge where tick_en is high and no write targets it, and holds when tick_en is low. From 0xFFFFFFFF it wraps to 0x00000000.
- R3: A write to a current-time register loads the written value on that clock edge. The write takes priority over a tick in the same cycle. Reads return the live counter value.
- R4: The byte offsets are: channel 0 at 0x00 (count), 0x04 (bite), 0x08 (bark) and 0x0C (control); channel 1 at 0x10, 0x14 and 0x1C; channel 2 at 0x20, 0x24 and 0x2C. Every other offset, including 0x18, 0x28, 0x30 and any offset that is not word aligned, reads zero and ignores writes.
- R5: The control word has interrupt enable at bit 0, interrupt status at bit 1 and reset enable at bit 2. Bits 31:3 read zero. On channels 1 and 2, bits 1:0 also read zero.
- R6: A channel's reset request is registered. It is high in the cycle after a clock edge at which reset enable was set and count >= bite (unsigned). It falls at the first edge after that condition stops holding.
- R7: The request from channel 0 drives rst_recovery_req. The OR of the requests from channels 1 and 2 drives rst_system_req.
- R8: On channel 0, the status bit becomes 1 at any clock edge where interrupt enable was set and count >= bark. irq equals status AND interrupt enable.
- R9: Writing a control word with bit 1 set clears the status bit, unless the bark condition of R8 holds at that same edge, in which case the bit stays set. Writing with bit 1 clear leaves the status bit unchanged.
- R10: With reset enable set, writing bite = 0 and count = 0 raises the reset request one clock after the last of those writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Reference tick; counters advance while high |
| bus_we | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| rst_recovery_req | output | 1 | Recovery reset request from channel 0 |
| rst_system_req | output | 1 | Normal reset request from channel 1 or 2 |
| irq | output | 1 | Channel 0 bark interrupt |

## Verification
Counting is driven in three ways: long runs with the tick enabled, gated runs with the tick off, and a start just below the 32-bit limit. Together these separate a stalled or double-stepping counter from one that saturates instead of wrapping. The bite tests set the counter below, at and above the compare value and then move the compare upward. This exposes a strict-greater compare, a latched request, or a request routed to the wrong output. The bark flag is cleared three ways: while the compare still holds, after the counter has been rewound, and with a zero in the status bit. These cases distinguish write-one-to-clear from plain write, and show whether setting or clearing wins. Writes to holes and to reserved bits confirm that neither changes any readable state.

// File: rtl/wdog3_pkg.sv
package wdog3_pkg;
  localparam int WD_W = 32;
  localparam int REG_CUR  = 0;
  localparam int REG_BITE = 1;
  localparam int REG_BARK = 2;
  localparam int REG_CTRL = 3;
  localparam int CTRL_IE = 0;
  localparam int CTRL_ST = 1;
  localparam int CTRL_RE = 2;
  localparam int CTRL_W  = 3;

  typedef struct packed {
    logic [WD_W-1:0]   cur;
    logic [WD_W-1:0]   bite;
    logic [WD_W-1:0]   bark;
    logic [CTRL_W-1:0] ctrl;
  } chan_view_t;
endpackage

// File: rtl/wdog_chan.sv
module wdog_chan
  import wdog3_pkg::*;
#(
  parameter bit HAS_BARK = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic [3:0]      wr_sel,
  input  logic [WD_W-1:0] wdata,
  output chan_view_t      view_o,
  output logic            req_o,
  output logic            irq_o
);
  logic [WD_W-1:0] cnt_q, cnt_d;
  logic [WD_W-1:0] bite_q, bite_d;
  logic            re_q, re_d;
  logic            req_q, req_d;
  logic [WD_W-1:0] bark_v;
  logic            ie_v, st_v;

  // counter: software write wins over tick
  always_comb begin
    cnt_d = cnt_q;
    if (wr_sel[REG_CUR])
      cnt_d = wdata;
    else if (tick_en)
      cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    bite_d = bite_q;
    re_d   = re_q;
    if (wr_sel[REG_BITE]) bite_d = wdata;
    if (wr_sel[REG_CTRL]) re_d   = wdata[CTRL_RE];
    req_d = re_q && (cnt_q >= bite_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bite_q <= '0;
      re_q   <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bite_q <= bite_d;
      re_q   <= re_d;
      req_q  <= req_d;
    end
  end

  generate
    if (HAS_BARK) begin : g_bark
      logic [WD_W-1:0] bark_q, bark_d;
      logic            ie_q, ie_d;
      logic            st_q, st_d;
      logic            w1c;

      always_comb begin
        bark_d = bark_q;
        ie_d   = ie_q;
        if (wr_sel[REG_BARK]) bark_d = wdata;
        if (wr_sel[REG_CTRL]) ie_d   = wdata[CTRL_IE];
        w1c  = wr_sel[REG_CTRL] && wdata[CTRL_ST];
        // set has priority over write-one-to-clear
        st_d = (st_q && !w1c) || (ie_q && (cnt_q >= bark_q));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bark_q <= '0;
          ie_q   <= 1'b0;
          st_q   <= 1'b0;
        end else begin
          bark_q <= bark_d;
          ie_q   <= ie_d;
          st_q   <= st_d;
        end
      end

      assign bark_v = bark_q;
      assign ie_v   = ie_q;
      assign st_v   = st_q;
    end else begin : g_nobark
      assign bark_v = '0;
      assign ie_v   = 1'b0;
      assign st_v   = 1'b0;
    end
  endgenerate

  assign view_o.cur  = cnt_q;
  assign view_o.bite = bite_q;
  assign view_o.bark = bark_v;
  assign view_o.ctrl = {re_q, st_v, ie_v};
  assign req_o       = req_q;
  assign irq_o       = st_v & ie_v;
endmodule

// File: rtl/wdog_dec.sv
module wdog_dec
  import wdog3_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_CH   = 3,
  parameter int BARK_CH = 0
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0][3:0] wr_sel,
  output logic              hit,
  output logic [ADDR_W-5:0] ch_idx,
  output logic [1:0]        reg_idx
);
  assign ch_idx  = addr[ADDR_W-1:4];
  assign reg_idx = addr[3:2];

  always_comb begin
    hit = (addr[1:0] == 2'b00) && (int'(ch_idx) < N_CH);
    if (reg_idx == 2'(REG_BARK) && int'(ch_idx) != BARK_CH)
      hit = 1'b0;
  end

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_sel
      for (genvar r = 0; r < 4; r++) begin : g_reg
        assign wr_sel[c][r] = we && hit && (int'(ch_idx) == c) && (int'(reg_idx) == r);
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog3_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_CH   = 3
) (
  input  chan_view_t [N_CH-1:0] views,
  input  logic                  hit,
  input  logic [ADDR_W-5:0]     ch_idx,
  input  logic [1:0]            reg_idx,
  output logic [WD_W-1:0]       rdata
);
  chan_view_t sel;

  always_comb begin
    sel   = '0;
    rdata = '0;
    for (int c = 0; c < N_CH; c++)
      if (int'(ch_idx) == c) sel = views[c];
    if (hit) begin
      case (reg_idx)
        2'(REG_CUR):  rdata = sel.cur;
        2'(REG_BITE): rdata = sel.bite;
        2'(REG_BARK): rdata = sel.bark;
        default:      rdata = {{(WD_W-CTRL_W){1'b0}}, sel.ctrl};
      endcase
    end
  end
endmodule

// File: rtl/wdog3_top.sv
module wdog3_top
  import wdog3_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_CH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WD_W-1:0]   bus_wdata,
  output logic [WD_W-1:0]   bus_rdata,
  output logic              rst_recovery_req,
  output logic              rst_system_req,
  output logic              irq
);
  localparam int CH_W = ADDR_W - 4;

  logic [N_CH-1:0][3:0] wr_sel;
  logic                 hit;
  logic [CH_W-1:0]      ch_idx;
  logic [1:0]           reg_idx;
  chan_view_t [N_CH-1:0] views;
  logic [N_CH-1:0]      req;
  logic [N_CH-1:0]      chan_irq;

  wdog_dec #(.ADDR_W(ADDR_W), .N_CH(N_CH), .BARK_CH(0)) u_dec (
    .we(bus_we), .addr(bus_addr), .wr_sel(wr_sel),
    .hit(hit), .ch_idx(ch_idx), .reg_idx(reg_idx)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      wdog_chan #(.HAS_BARK(c == 0)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_sel(wr_sel[c]), .wdata(bus_wdata),
        .view_o(views[c]), .req_o(req[c]), .irq_o(chan_irq[c])
      );
    end
  endgenerate

  wdog_rdmux #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_rd (
    .views(views), .hit(hit), .ch_idx(ch_idx),
    .reg_idx(reg_idx), .rdata(bus_rdata)
  );

  assign rst_recovery_req = req[0];
  assign rst_system_req   = |req[N_CH-1:1];
  assign irq              = chan_irq[0];
endmodule

// File: rtl/wdog3_chk.sv
module wdog3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        bus_we,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        rst_recovery_req,
  input logic        rst_system_req,
  input logic        irq
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R2: tick while reading channel 0 count advances it by one
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!bus_we && tick_en && bus_addr == 6'h00) |=>
      (bus_addr != 6'h00 || bus_rdata == $past(bus_rdata) + 32'd1));

  // R3: written count is visible on the next cycle
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (bus_we && bus_addr == 6'h00) |=>
      (bus_addr != 6'h00 || bus_rdata == $past(bus_wdata)));

  // R4: holes read zero
  a_r4_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h18 || bus_addr == 6'h28 || bus_addr[5:4] == 2'b11 || bus_addr[1:0] != 2'b00)
      |-> bus_rdata == 32'd0);

  // R5: reserved control bits read zero
  a_r5_ctrl_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h0C) |-> bus_rdata[31:3] == 29'd0);

  // R5: channel 1 and 2 have no interrupt bits
  a_r5_ctrl_noirq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h1C || bus_addr == 6'h2C) |-> bus_rdata[31:0] <= 32'd4);

  // R8: disabling the interrupt removes irq on the next cycle
  a_r8_irq_mask: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (bus_we && bus_addr == 6'h0C && !bus_wdata[0]) |=> !irq);
endmodule

bind wdog3_top wdog3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rst_recovery_req(rst_recovery_req), .rst_system_req(rst_system_req),
  .irq(irq)
);

// File: tb/sim_wdog3_top.sv
`timescale 1ns/100ps
module sim_wdog3_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_recovery_req, rst_system_req, irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  wdog3_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_recovery_req(rst_recovery_req), .rst_system_req(rst_system_req),
    .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt [3];
  logic [31:0] m_bite [3];
  logic [31:0] m_bark;
  bit          m_ie, m_st;
  bit          m_re [3];
  bit          m_req [3];

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_cnt[0];
      6'h04: return m_bite[0];
      6'h08: return m_bark;
      6'h0C: return {29'd0, m_re[0], m_st, m_ie};
      6'h10: return m_cnt[1];
      6'h14: return m_bite[1];
      6'h1C: return {29'd0, m_re[1], 2'b00};
      6'h20: return m_cnt[2];
      6'h24: return m_bite[2];
      6'h2C: return {29'd0, m_re[2], 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_bite[i] = 0; m_re[i] = 0; m_req[i] = 0;
      end
      m_bark = 0; m_ie = 0; m_st = 0;
    end else begin
      bit st_n;
      bit req_n [3];
      for (int i = 0; i < 3; i++) req_n[i] = m_re[i] && (m_cnt[i] >= m_bite[i]);
      st_n = (m_st && !(bus_we && bus_addr == 6'h0C && bus_wdata[1])) ||
             (m_ie && (m_cnt[0] >= m_bark));
      for (int i = 0; i < 3; i++) begin
        if (bus_we && bus_addr == 6'(16*i)) m_cnt[i] = bus_wdata;
        else if (tick_en) m_cnt[i] = m_cnt[i] + 1;
        if (bus_we && bus_addr == 6'(16*i+4)) m_bite[i] = bus_wdata;
        if (bus_we && bus_addr == 6'(16*i+12)) m_re[i] = bus_wdata[2];
        m_req[i] = req_n[i];
      end
      if (bus_we && bus_addr == 6'h08) m_bark = bus_wdata;
      if (bus_we && bus_addr == 6'h0C) m_ie = bus_wdata[0];
      m_st = st_n;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({phase, " recovery"}, {31'd0, rst_recovery_req}, {31'd0, m_req[0]});
      check({phase, " system"},   {31'd0, rst_system_req},   {31'd0, m_req[1] | m_req[2]});
      check({phase, " irq"},      {31'd0, irq},              {31'd0, m_st & m_ie});
      check({phase, " rdata"},    bus_rdata,                 m_read(bus_addr));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); #0.5;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #0.5;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    phase = "R1";
    check("R1 recovery", {31'd0, rst_recovery_req}, 32'd0);
    check("R1 system", {31'd0, rst_system_req}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    foreach (m_cnt[i]) begin end
    for (int a = 0; a < 48; a += 4) rd(6'(a), 32'd0, "R1 reg zero");

    // R2 gated counting and wrap
    phase = "R2";
    wr(6'h10, 32'd100);
    tick_en = 1'b1; step(5); tick_en = 1'b0;
    rd(6'h10, 32'd105, "R2 five ticks");
    step(3);
    rd(6'h10, 32'd105, "R2 hold without tick");
    wr(6'h20, 32'hFFFF_FFFE);
    tick_en = 1'b1; step(3); tick_en = 1'b0;
    rd(6'h20, 32'd1, "R2 wrap");

    // R3 write beats tick
    phase = "R3";
    @(negedge clk); #0.5;
    tick_en = 1'b1; bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 32'd7;
    @(negedge clk); #0.5;
    tick_en = 1'b0; bus_we = 1'b0;
    rd(6'h00, 32'd7, "R3 write priority");
    tick_en = 1'b1; bus_addr = 6'h00; step(4); tick_en = 1'b0;
    rd(6'h00, 32'd11, "R3 live read");

    // R4 holes
    phase = "R4";
    wr(6'h18, 32'hDEAD_BEEF);
    wr(6'h28, 32'hDEAD_BEEF);
    wr(6'h31, 32'hDEAD_BEEF);
    wr(6'h01, 32'hDEAD_BEEF);
    rd(6'h18, 32'd0, "R4 hole 0x18");
    rd(6'h30, 32'd0, "R4 hole 0x30");
    rd(6'h08, 32'd0, "R4 bark untouched");
    rd(6'h00, 32'd11, "R4 count untouched");
    rd(6'h01, 32'd0, "R4 unaligned");

    // R5 reserved bits, R6/R7 system request from channel 1
    phase = "R5";
    wr(6'h14, 32'd1000);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C, 32'd4, "R5 ch1 ctrl");
    phase = "R6";
    step(1);
    check("R7 ch1 system req", {31'd0, rst_system_req}, 32'd0);
    wr(6'h10, 32'd1000);
    step(1);
    check("R6 equal compare", {31'd0, rst_system_req}, 32'd1);
    check("R7 not recovery", {31'd0, rst_recovery_req}, 32'd0);
    wr(6'h14, 32'd2000);
    step(1);
    check("R6 drop after bite raised", {31'd0, rst_system_req}, 32'd0);
    wr(6'h1C, 32'd0);
    wr(6'h2C, 32'd4);
    wr(6'h24, 32'd0);
    step(1);
    check("R7 ch2 system req", {31'd0, rst_system_req}, 32'd1);
    wr(6'h2C, 32'd0);
    step(1);
    check("R6 drop after disable", {31'd0, rst_system_req}, 32'd0);

    // R10 immediate recovery request on channel 0
    phase = "R10";
    wr(6'h04, 32'hFFFF_0000);
    wr(6'h0C, 32'd4);
    wr(6'h04, 32'd0);
    wr(6'h00, 32'd0);
    step(1);
    check("R10 recovery req", {31'd0, rst_recovery_req}, 32'd1);
    wr(6'h0C, 32'd0);
    step(1);
    check("R6 recovery drop", {31'd0, rst_recovery_req}, 32'd0);

    // R8 bark interrupt, R9 clear semantics
    phase = "R8";
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h08, 32'd10);
    wr(6'h00, 32'd0);
    wr(6'h0C, 32'd1);
    tick_en = 1'b1; step(8); tick_en = 1'b0;
    check("R8 below bark", {31'd0, irq}, 32'd0);
    tick_en = 1'b1; step(4); tick_en = 1'b0;
    step(1);
    check("R8 irq raised", {31'd0, irq}, 32'd1);
    phase = "R9";
    wr(6'h0C, 32'd3);
    step(1);
    check("R9 set wins", {31'd0, irq}, 32'd1);
    wr(6'h00, 32'd0);
    wr(6'h0C, 32'd1);
    rd(6'h0C, 32'd3, "R9 zero keeps status");
    wr(6'h0C, 32'd3);
    rd(6'h0C, 32'd1, "R9 one clears");
    check("R9 irq low", {31'd0, irq}, 32'd0);
    // status kept while masked, irq follows mask
    phase = "R8";
    tick_en = 1'b1; step(12); tick_en = 1'b0;
    step(1);
    wr(6'h0C, 32'd0);
    rd(6'h0C, 32'd2, "R8 status kept while masked");
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    step(2);
    finish_run();
  end
endmodule